// File: doc/BRIEF.md
# Computer-Operating-Properly Watchdog

This block watches that software keeps running. Once per bus cycle (an enable pulse on the fast clock) it counts upward. The count passes through a fixed power-of-two pre-divider of 2^15 bus cycles and then through a post-divider whose length a 2-bit rate code selects. If software fails to strobe the service input before the full period ends, the block raises a reset request for exactly one clock. It then starts a new period.

The rate code comes from a control register outside the block. That register's write protection and its reset value live there. Its reset value is code 00, the shortest period. With the default 2^15 pre-divider and a 2 MHz bus clock, the nominal time-out is about 16.4 ms at code 00 and about 1.05 s at code 11. The longest period, 2^21 bus cycles, fits in the counter chain. A parameter shrinks the pre-divider for simulation. The ratios between the four rate settings stay the same.

Top module: `cop_watchdog`

## Requirements
- R1: Reset drives resetReq low and clears all counting. The first request after reset is released comes one full period later.
- R2: With rate code 00 and busEn high on every clock, resetReq rises after exactly 2^PRE_BITS enabled clocks. It never comes after fewer than 2^PRE_BITS enabled clocks.
- R3: Rate code r multiplies the period by 4^r. Code 00 gives a factor of 1, 01 gives 4, 10 gives 16 and 11 gives 64.
- R4: resetReq is high for one clock only. Counting restarts from zero on the clock that raises it, so the next request follows one full period later.
- R5: A high service input on a clock restarts both dividers from zero and suppresses any request that this clock would raise. The next request comes one full period after the service.
- R6: Clocks with busEn low are not counted and never raise a request.
- R7: While copEn is low, resetReq stays low and the count is cleared. Counting resumes from zero when copEn returns high.
- R8: A new rate code takes effect at once, in the middle of a count. If the post-divider has already reached or passed the new limit, the request comes at the next wrap of the pre-divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Synchronous reset, active low |
| busEn | input | 1 | One-clock pulse marking a bus cycle to count |
| copEn | input | 1 | Watchdog enable; low holds the count at zero |
| rateSel | input | RATE_W | Post-divide code: factor 4^code |
| service | input | 1 | Service strobe that restarts the period |
| resetReq | output | 1 | One-clock reset request on time-out |

## Verification
The only output is the request pulse. A wrong count or a wrong post-divide limit therefore shows up only at the next expected expiry, when the request comes a clock early, a clock late, or at a multiple of the right period. A corrupted counter can stay hidden for up to a whole period. For that reason, a reference model checks the output on every clock, and the bench also measures each period from a known restart point. Each service, disable and rate change is followed by a full measured period, so that stale counter state appears as a timing mismatch within one period.

// File: rtl/cop_pkg.sv
`timescale 1ns/1ps
package cop_pkg;
  // Strobes from the control path to the counter datapath
  typedef struct packed {
    logic clear;  // restart both dividers from zero
    logic count;  // advance the pre-divider by one bus cycle
  } copStrobe_t;
endpackage

// File: rtl/cop_datapath.sv
`timescale 1ns/1ps
module cop_datapath
  import cop_pkg::*;
#(
  parameter int PRE_BITS = 15,
  parameter int RATE_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  copStrobe_t        strb,
  input  logic [RATE_W-1:0] rateSel,
  output logic              termHit
);
  // Post-divider must reach 4^(2^RATE_W - 1) - 1
  localparam int POST_W = 2 * ((1 << RATE_W) - 1);
  localparam logic [PRE_BITS-1:0] PRE_ONE  = PRE_BITS'(1);
  localparam logic [POST_W-1:0]   POST_ONE = POST_W'(1);
  localparam logic [POST_W:0]     SPAN_ONE = (POST_W + 1)'(1);

  logic [PRE_BITS-1:0] preCnt;
  logic [POST_W-1:0]   postCnt;
  logic [POST_W:0]     postSpan;
  logic [POST_W:0]     postLast;
  logic                preWrap;

  // Post-divide factor is 4^rateSel; last index is that minus one
  always_comb begin
    postSpan = SPAN_ONE << {rateSel, 1'b0};
    postLast = postSpan - SPAN_ONE;
  end

  assign preWrap = &preCnt;
  // >= so that lowering the rate mid-count still expires promptly
  assign termHit = preWrap && ({1'b0, postCnt} >= postLast);

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      preCnt  <= '0;
      postCnt <= '0;
    end else if (strb.count) begin
      preCnt <= preCnt + PRE_ONE;
      if (preWrap) postCnt <= postCnt + POST_ONE;
    end
  end
endmodule

// File: rtl/cop_ctrl.sv
`timescale 1ns/1ps
module cop_ctrl
  import cop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busEn,
  input  logic       copEn,
  input  logic       service,
  input  logic       termHit,
  output copStrobe_t strb,
  output logic       resetReq
);
  logic countOk;
  logic expire;

  // Service wins over counting and over expiry
  assign countOk = copEn && busEn && !service;
  assign expire  = countOk && termHit;

  always_comb begin
    strb.count = countOk;
    strb.clear = !copEn || service || expire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resetReq <= 1'b0;
    else       resetReq <= expire;
  end
endmodule

// File: rtl/cop_watchdog.sv
`timescale 1ns/1ps
module cop_watchdog
  import cop_pkg::*;
#(
  parameter int PRE_BITS = 15,
  parameter int RATE_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              copEn,
  input  logic [RATE_W-1:0] rateSel,
  input  logic              service,
  output logic              resetReq
);
  copStrobe_t strb;
  logic       termHit;

  cop_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busEn    (busEn),
    .copEn    (copEn),
    .service  (service),
    .termHit  (termHit),
    .strb     (strb),
    .resetReq (resetReq)
  );

  cop_datapath #(
    .PRE_BITS (PRE_BITS),
    .RATE_W   (RATE_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rateSel (rateSel),
    .termHit (termHit)
  );
endmodule

// File: rtl/cop_watchdog_chk.sv
`timescale 1ns/1ps
module cop_watchdog_chk #(
  parameter int PRE_BITS = 15,
  parameter int RATE_W   = 2
) (
  input logic clk,
  input logic rstN,
  input logic busEn,
  input logic copEn,
  input logic service,
  input logic resetReq
);
  localparam int SEEN_W  = PRE_BITS + 2 * ((1 << RATE_W) - 1) + 1;
  localparam int MIN_GAP = 1 << PRE_BITS;

  // Enabled bus cycles since the last restart (observed at the ports)
  logic [SEEN_W-1:0] seen;
  always_ff @(posedge clk) begin
    if (!rstN || !copEn || service) seen <= '0;
    else if (resetReq)              seen <= busEn ? SEEN_W'(1) : '0;
    else if (busEn)                 seen <= seen + SEEN_W'(1);
  end

  assert_one_clock_R4: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
  assert_service_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    service |=> !resetReq);
  assert_idle_bus_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |=> !resetReq);
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !copEn |=> !resetReq);
  assert_min_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (seen >= SEEN_W'(MIN_GAP)));
endmodule

bind cop_watchdog cop_watchdog_chk #(
  .PRE_BITS (PRE_BITS),
  .RATE_W   (RATE_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busEn    (busEn),
  .copEn    (copEn),
  .service  (service),
  .resetReq (resetReq)
);

// File: tb/cop_watchdog_tb.sv
`timescale 1ns/1ps
module cop_watchdog_tb;
  localparam int PRE_BITS = 4;
  localparam int RATE_W   = 2;
  localparam int BASE     = 1 << PRE_BITS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busEn = 1'b1;
  logic copEn = 1'b1;
  logic [RATE_W-1:0] rateSel = '0;
  logic service = 1'b0;
  logic resetReq;

  int nChecks = 0;
  int nFail = 0;
  string curTag = "R1";
  bit started = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cop_watchdog #(.PRE_BITS(PRE_BITS), .RATE_W(RATE_W)) u_dut (
    .clk(clk), .rstN(rstN), .busEn(busEn), .copEn(copEn),
    .rateSel(rateSel), .service(service), .resetReq(resetReq)
  );

  // Behavioural reference: one integer of enabled cycles since restart
  int mCnt = 0;
  bit mReq = 1'b0;
  always @(posedge clk) begin
    int pre, post, lim;
    if (!rstN || !copEn || service) begin
      mCnt = 0; mReq = 1'b0;
    end else if (busEn) begin
      pre = mCnt % BASE;
      post = mCnt / BASE;
      lim = 1 << (2 * int'(rateSel));
      if (pre == BASE - 1 && post >= lim - 1) begin
        mCnt = 0; mReq = 1'b1;
      end else begin
        mCnt = mCnt + 1; mReq = 1'b0;
      end
    end else begin
      mReq = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      nChecks++;
      if (resetReq !== mReq) begin
        nFail++;
        $display("FAIL %s model compare at %0t: resetReq=%0b expected %0b",
                 curTag, $time, resetReq, mReq);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  // Counts edges until resetReq is seen; returns limit+1 if never
  task automatic waitReq(input int limit, output int k);
    k = 0;
    forever begin
      @(posedge clk); k++;
      @(negedge clk);
      if (resetReq) break;
      if (k > limit) break;
    end
  endtask

  task automatic serviceNow();
    step(); service = 1'b1;
    step(); service = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog: run hung, got %0d expected %0d", 0, 1);
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int k, tot;
    bit seenReq;
    // R1 reset state
    repeat (3) step();
    started = 1'b1;
    check(resetReq == 1'b0, "R1 reset output", int'(resetReq), 0);
    rstN = 1'b1;
    curTag = "R2";
    waitReq(5000, k);
    check(k == BASE, "R2 first period rate 00", k, BASE);
    curTag = "R4";
    @(posedge clk); @(negedge clk);
    check(resetReq == 1'b0, "R4 pulse one clock", int'(resetReq), 0);
    waitReq(5000, k);
    check(k == BASE - 1, "R4 restart after expiry", k + 1, BASE);

    // R3 each rate code
    curTag = "R3";
    for (int r = 1; r < 4; r++) begin
      rateSel = RATE_W'(r);
      serviceNow();
      waitReq(5000, k);
      check(k == (BASE << (2 * r)), "R3 period for rate code", k, BASE << (2 * r));
    end

    // R8 lower the rate mid-count: 3 -> 0
    curTag = "R8";
    rateSel = 2'd3;
    serviceNow();
    repeat (99) step();
    rateSel = 2'd0;
    waitReq(5000, k);
    tot = 99 + k;
    check(tot == 7 * BASE, "R8 lower rate past limit", tot, 7 * BASE);
    // R8 raise the rate mid-count: 0 -> 1
    serviceNow();
    repeat (10) step();
    rateSel = 2'd1;
    waitReq(5000, k);
    tot = 10 + k;
    check(tot == 4 * BASE, "R8 raise rate mid-count", tot, 4 * BASE);
    rateSel = 2'd0;

    // R6 busEn every other clock
    curTag = "R6";
    serviceNow();
    busEn = 1'b0;
    k = 0;
    forever begin
      @(posedge clk); k++;
      @(negedge clk);
      if (resetReq || k > 5000) break;
      busEn = ~busEn;
    end
    busEn = 1'b1;
    check(k == 2 * BASE, "R6 idle bus cycles not counted", k, 2 * BASE);

    // R7 disable
    curTag = "R7";
    step();
    copEn = 1'b0;
    seenReq = 1'b0;
    repeat (5 * BASE) begin
      step();
      if (resetReq) seenReq = 1'b1;
    end
    check(!seenReq, "R7 no request while disabled", int'(seenReq), 0);
    copEn = 1'b1;
    waitReq(5000, k);
    check(k == BASE, "R7 restart after enable", k, BASE);

    // R5 service on the expiry clock
    curTag = "R5";
    serviceNow();
    repeat (BASE - 1) step();
    service = 1'b1;
    step();
    service = 1'b0;
    check(resetReq == 1'b0, "R5 service suppresses expiry", int'(resetReq), 0);
    waitReq(5000, k);
    check(k == BASE, "R5 full period after service", k, BASE);

    // R1 reset in mid-count
    curTag = "R1";
    serviceNow();
    repeat (7) step();
    rstN = 1'b0;
    step();
    check(resetReq == 1'b0, "R1 output low in reset", int'(resetReq), 0);
    rstN = 1'b1;
    waitReq(5000, k);
    check(k == BASE, "R1 full period after reset", k, BASE);

    repeat (3) step();
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule